// File: doc/BRIEF.md
# Clock Domain Divider and Selector

This block produces the clock for one clock domain. Five free-running input clocks arrive on `src_clk`. A glitch-free switch picks one of them, and a divider then slows the chosen clock down. The divide ratio is the sum of two fields plus two: a high-phase count and a low-phase count. The output stays high for (high count + 1) source cycles and low for (low count + 1) source cycles. A bypass bit sends the chosen clock straight to the output without dividing it. A gate input can hold the output low.

Software controls the block through one 32-bit configuration word. The word is written with `cfg_we` and `cfg_wdata` and read back on `cfg_rdata`, all on `reg_clk`. Two read-only flags report work that is still in progress. The switch flag is set until the newly selected source is driving the output. The update flag is set from the moment new counts are requested until the divider has loaded them. Software polls both flags.

Two parameters select variants. `CNT_W = 3` narrows both count fields to three bits, which limits the ratio to 2..16. `FIXED_SRC = 1` locks the selection to source 4.

Top module: `clk_domain_gen`

## Requirements
- R1: After reset the configuration word reads 0x0000_0001, or 0x0000_0004 when the source is fixed. The output then runs at the source-1 frequency divided by 2.
- R2: Bits [2:0] select the source. Code c in 0..4 routes `src_clk[c]` to the divider.
- R3: A write with a source code of 5, 6 or 7 leaves the selection unchanged and does not raise the switch flag. Every other field of that write still takes effect.
- R4: Bit 3 reads 1 from the write that changes the source until the new source drives the output. It then reads 0.
- R5: At most one source is enabled at any time. The old source is released while it is low, before the new one is enabled.
- R6: With bit 24 clear, the output is high for W+1 and low for H+1 cycles of the source. W is bits [19:16] and H is bits [23:20].
- R7: Writing 1 to bit 25 sets it and stages W and H. Bit 25 clears by itself once the divider has loaded the staged values. While bit 25 is set, writes to W, H and bit 25 are ignored.
- R8: With bit 24 set, the output equals the selected source, undivided.
- R9: New counts and a bypass change take effect only at the end of a complete output period. No high or low phase has a length other than the old or the new setting.
- R10: While `gate_en` is low, the output is held low. The gate changes only while the undivided-or-divided clock is low.
- R11: With `CNT_W = 3`, bits 19 and 23 read 0 and the largest ratio is 16.
- R12: With `FIXED_SRC = 1`, bits [2:0] always read 4. Writes to that field are ignored and the switch flag never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Configuration register clock |
| reg_rst_n | input | 1 | Active-low asynchronous reset for the whole block |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word and status flags |
| src_clk | input | 5 | Candidate source clocks, index = select code |
| gate_en | input | 1 | Output gate, low forces the output low |
| clk_out | output | 1 | Domain clock output |

## Verification
The assertions check the following on every cycle:
- at most one source enable is active;
- the select code stays legal, and an illegal code never moves it;
- a source change raises the switch flag;
- staged counts stay frozen while an update is pending;
- the divider counter stays inside the active phase length;
- the active counts change only at a period boundary.

Only the bench scenarios can show the rest: the measured high and low widths in ns for each source and ratio, the undivided bypass output, the absence of runt phases across an update, the output held low by the gate, and the variant readbacks.

// File: rtl/clk_domain_gen.sv
`timescale 1ns/1ps
module clk_domain_gen #(
  parameter int CNT_W     = 4,
  parameter bit FIXED_SRC = 1'b0
) (
  input  logic        reg_clk,
  input  logic        reg_rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [4:0]  src_clk,
  input  logic        gate_en,
  output logic        clk_out
);
  localparam int NSRC = 5;
  localparam logic [2:0] RST_SEL = FIXED_SRC ? 3'd4 : 3'd1;

  // ---------------- register domain ----------------
  logic [2:0]       sel_q;
  logic             busy_q, byp_q, pend_q, req_tog;
  logic [CNT_W-1:0] wait_q, hold_q;
  logic [NSRC-1:0]  src_en, en_bk1, en_bk2;
  logic             ack_tog, ack_s1, ack_s2;

  wire [2:0] wsel     = cfg_wdata[2:0];
  wire       sel_ok   = !FIXED_SRC && (wsel <= 3'd4) && (wsel != sel_q);
  wire       src_done = (en_bk2 == (5'd1 << sel_q));

  always_ff @(posedge reg_clk or negedge reg_rst_n) begin
    if (!reg_rst_n) begin
      sel_q   <= RST_SEL;
      busy_q  <= 1'b0;
      byp_q   <= 1'b0;
      pend_q  <= 1'b0;
      req_tog <= 1'b0;
      wait_q  <= '0;
      hold_q  <= '0;
    end else begin
      if (cfg_we && sel_ok) begin
        sel_q  <= wsel;
        busy_q <= 1'b1;
      end else if (busy_q && src_done) begin
        busy_q <= 1'b0;
      end
      if (cfg_we) byp_q <= cfg_wdata[24];
      if (cfg_we && !pend_q) begin
        wait_q <= cfg_wdata[16 +: CNT_W];
        hold_q <= cfg_wdata[20 +: CNT_W];
        if (cfg_wdata[25]) begin
          pend_q  <= 1'b1;
          req_tog <= ~req_tog;
        end
      end else if (pend_q && (ack_s2 == req_tog)) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge reg_clk or negedge reg_rst_n) begin
    if (!reg_rst_n) begin
      en_bk1 <= '0;
      en_bk2 <= '0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      en_bk1 <= src_en;
      en_bk2 <= en_bk1;
      ack_s1 <= ack_tog;
      ack_s2 <= ack_s1;
    end
  end

  assign cfg_rdata = {6'b0, pend_q, byp_q, 4'(hold_q), 4'(wait_q), 12'b0, busy_q, sel_q};

  logic unused_wbits;
  assign unused_wbits = ^{cfg_wdata[31:26], cfg_wdata[23], cfg_wdata[19], cfg_wdata[15:3]};

  // ---------------- glitch-free source switch ----------------
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic s1, s2, en_q;
    wire  go = (sel_q == 3'(i)) && ((src_en & ~(5'd1 << i)) == '0);
    always_ff @(posedge src_clk[i] or negedge reg_rst_n) begin
      if (!reg_rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= go;
        s2 <= s1;
      end
    end
    always_ff @(negedge src_clk[i] or negedge reg_rst_n) begin
      if (!reg_rst_n) en_q <= 1'b0;
      else            en_q <= s2 & go;
    end
    assign src_en[i] = en_q;
  end

  wire mclk = |(src_clk & src_en);

  // ---------------- divider domain ----------------
  logic mr1, mr2;
  always_ff @(posedge mclk or negedge reg_rst_n) begin
    if (!reg_rst_n) begin
      mr1 <= 1'b0;
      mr2 <= 1'b0;
    end else begin
      mr1 <= 1'b1;
      mr2 <= mr1;
    end
  end
  wire mrst_n = mr2;

  logic             rq1, rq2, by1, by2, byp_act, ph, gt1, gt2, gate_q;
  logic [CNT_W-1:0] cnt, act_w, act_h;
  wire period_end = !ph && (cnt == act_h);

  always_ff @(posedge mclk or negedge mrst_n) begin
    if (!mrst_n) begin
      rq1 <= 1'b0;  rq2 <= 1'b0;
      by1 <= 1'b0;  by2 <= 1'b0;
      gt1 <= 1'b0;  gt2 <= 1'b0;
    end else begin
      rq1 <= req_tog;  rq2 <= rq1;
      by1 <= byp_q;    by2 <= by1;
      gt1 <= gate_en;  gt2 <= gt1;
    end
  end

  always_ff @(posedge mclk or negedge mrst_n) begin
    if (!mrst_n) begin
      ph      <= 1'b1;
      cnt     <= '0;
      act_w   <= '0;
      act_h   <= '0;
      byp_act <= 1'b0;
      ack_tog <= 1'b0;
    end else if (ph) begin
      if (cnt == act_w) begin
        ph  <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (period_end) begin
      ph      <= 1'b1;
      cnt     <= '0;
      byp_act <= by2;
      if (rq2 != ack_tog) begin
        act_w   <= wait_q;
        act_h   <= hold_q;
        ack_tog <= rq2;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(negedge mclk or negedge mrst_n) begin
    if (!mrst_n)              gate_q <= 1'b0;
    else if (!ph || byp_act)  gate_q <= gt2;
  end

  wire pre_clk = byp_act ? mclk : ph;
  assign clk_out = pre_clk & gate_q;

  // ---------------- assertions ----------------
  AST_SEL_LEGAL: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
    sel_q <= 3'd4); // R2
  AST_ILLEGAL_SEL_IGNORED: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
    (cfg_we && wsel > 3'd4) |=> $stable(sel_q)); // R3
  AST_BUSY_ON_SWITCH: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
    (cfg_we && sel_ok) |=> busy_q); // R4
  AST_ONE_SOURCE: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
    $onehot0(src_en)); // R5
  AST_COUNTS_FROZEN: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
    pend_q |=> ($stable(wait_q) && $stable(hold_q))); // R7
  AST_FIXED_SEL: assert property (@(posedge reg_clk) disable iff (!reg_rst_n)
    (!FIXED_SRC || (sel_q == 3'd4 && !busy_q))); // R12
  AST_CNT_BOUND: assert property (@(posedge mclk) disable iff (!mrst_n)
    cnt <= (ph ? act_w : act_h)); // R6
  AST_RELOAD_AT_END: assert property (@(posedge mclk) disable iff (!mrst_n)
    !period_end |=> ($stable(act_w) && $stable(act_h) && $stable(byp_act))); // R9
endmodule

// File: tb/clk_domain_gen_tb.sv
`timescale 1ns/1ps
module clk_domain_gen_tb;
  logic reg_clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_en = 1'b1;
  logic [2:0] we = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd_d, rd_m, rd_f;
  logic co_d, co_m, co_f;
  logic s0 = 0, s1 = 0, s2 = 0, s3 = 0, s4 = 0;
  logic [1:0] msel = 2'd0;
  int n_chk = 0, n_fail = 0;

  always #2  reg_clk = ~reg_clk;
  always #20 s0 = ~s0;
  always #5  s1 = ~s1;
  always #3  s2 = ~s2;
  always #7  s3 = ~s3;
  always #4  s4 = ~s4;
  wire [4:0] srcs = {s4, s3, s2, s1, s0};
  wire mon = (msel == 2'd0) ? co_d : (msel == 2'd1) ? co_m : co_f;

  clk_domain_gen u_dut (.reg_clk(reg_clk), .reg_rst_n(rst_n), .cfg_we(we[0]), .cfg_wdata(wd),
    .cfg_rdata(rd_d), .src_clk(srcs), .gate_en(gate_en), .clk_out(co_d));
  clk_domain_gen #(.CNT_W(3)) u_mem (.reg_clk(reg_clk), .reg_rst_n(rst_n), .cfg_we(we[1]),
    .cfg_wdata(wd), .cfg_rdata(rd_m), .src_clk(srcs), .gate_en(1'b1), .clk_out(co_m));
  clk_domain_gen #(.FIXED_SRC(1'b1)) u_fix (.reg_clk(reg_clk), .reg_rst_n(rst_n), .cfg_we(we[2]),
    .cfg_wdata(wd), .cfg_rdata(rd_f), .src_clk(srcs), .gate_en(1'b1), .clk_out(co_f));

  // sel, wait, hold, bypass, expected high ns, expected low ns
  localparam int NV = 8;
  localparam int VS[NV]  = '{1, 2, 3, 4, 0, 4, 2, 1};
  localparam int VW[NV]  = '{0, 2, 15, 0, 1, 0, 5, 7};
  localparam int VH[NV]  = '{0, 1, 15, 3, 0, 0, 5, 2};
  localparam bit VB[NV]  = '{0, 0, 0, 0, 0, 1, 1, 0};
  localparam int VHI[NV] = '{10, 18, 224, 8, 80, 4, 3, 80};
  localparam int VLO[NV] = '{10, 12, 224, 32, 40, 4, 3, 30};

  function automatic logic [31:0] mk(int s, int w, int h, bit b, bit u);
    return {6'b0, u, b, 4'(h), 4'(w), 12'b0, 1'b0, 3'(s)};
  endfunction

  function automatic logic [31:0] rdv(int which);
    case (which)
      0: return rd_d;
      1: return rd_m;
      default: return rd_f;
    endcase
  endfunction

  task automatic chk32(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chkr(string req, string what, real act, real exp);
    n_chk++;
    if (act < exp - 0.5 || act > exp + 0.5) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  task automatic wr(int which, logic [31:0] d);
    @(negedge reg_clk);
    wd = d;
    we[which] = 1'b1;
    @(negedge reg_clk);
    we = '0;
  endtask

  task automatic wait_idle(int which);
    while (rdv(which)[3] || rdv(which)[25]) @(negedge reg_clk);
  endtask

  task automatic measure(output real hi, output real lo);
    realtime t0, t1, t2;
    @(posedge mon); t0 = $realtime;
    @(negedge mon); t1 = $realtime;
    @(posedge mon); t2 = $realtime;
    hi = t1 - t0;
    lo = t2 - t1;
  endtask

  task automatic chk_period(string req, real eh, real el);
    real hi, lo;
    measure(hi, lo);
    chkr(req, "high width", hi, eh);
    chkr(req, "low width", lo, el);
  endtask

  initial begin
    #700000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    real hi, lo;
    int highs;
    #50 rst_n = 1'b1;
    #400;
    // R1 reset state
    chk32("R1", "reset word", rd_d, 32'h0000_0001);
    chk32("R1", "reset word narrow", rd_m, 32'h0000_0001);
    chk32("R12", "reset word fixed", rd_f, 32'h0000_0004);
    chk_period("R1", 10, 10);

    // table walk: R2 R6 R8 R7
    for (int k = 0; k < NV; k++) begin
      wr(0, mk(VS[k], VW[k], VH[k], VB[k], 1'b1));
      wait_idle(0);
      chk32("R7", "readback after update", rd_d, mk(VS[k], VW[k], VH[k], VB[k], 1'b0));
      #1500;
      chk_period(VB[k] ? "R2 R8" : "R2 R6", VHI[k], VLO[k]);
    end

    // R3 illegal source code ignored
    wr(0, mk(6, 7, 2, 0, 0));
    chk32("R3", "illegal select", rd_d[3:0], 4'b0001);
    #500;
    chk_period("R3", 80, 30);

    // R4 R5 busy flag across switch
    wr(0, mk(3, 7, 2, 0, 0));
    chk32("R4", "busy set", rd_d[3:0], 4'b1011);
    wait_idle(0);
    chk32("R4", "busy cleared", rd_d[3:0], 4'b0011);
    #300;
    chk_period("R4 R5", 112, 42);

    // R7 R9 pending update, ignored second write, no runt phases
    wr(0, mk(3, 1, 1, 0, 1));
    chk32("R7", "pending set", {31'b0, rd_d[25]}, 32'd1);
    wr(0, mk(3, 4, 4, 0, 1));
    for (int k = 0; k < 5; k++) begin
      measure(hi, lo);
      n_chk++;
      if (!((hi > 111.5 && hi < 112.5) || (hi > 27.5 && hi < 28.5)) ||
          !((lo > 41.5 && lo < 42.5) || (lo > 27.5 && lo < 28.5))) begin
        n_fail++;
        $display("FAIL R9 runt phase: actual %0.2f/%0.2f expected 112/42 or 28/28", hi, lo);
      end
    end
    wait_idle(0);
    chk32("R7", "counts written while pending ignored", rd_d[23:16], 8'h11);
    chk_period("R7", 28, 28);

    // R10 gate
    gate_en = 1'b0;
    #1500;
    highs = 0;
    for (int k = 0; k < 400; k++) begin
      #1;
      if (co_d) highs++;
    end
    chk32("R10", "high samples while gated", highs, 0);
    gate_en = 1'b1;
    #1500;
    chk_period("R10", 28, 28);

    // R11 narrow count fields
    wr(1, mk(1, 15, 15, 0, 1));
    wait_idle(1);
    chk32("R11", "narrow readback", rd_m, 32'h0077_0001);
    msel = 2'd1;
    #1500;
    chk_period("R11", 80, 80);

    // R12 fixed source
    msel = 2'd2;
    chk_period("R12", 8, 8);
    wr(2, mk(1, 0, 0, 0, 0));
    chk32("R12", "fixed select after write", rd_f[3:0], 4'b0100);
    #500;
    chk_period("R12", 8, 8);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule